// File: doc/BRIEF.md
# Exception State Registers

This block keeps the architectural record of the most recent trap or interrupt for a simple in-order processor. When the pipeline control raises an exception it latches the return address of the faulting instruction, the reason code and, for address faults, the offending data address. In the same cycle it pushes a three-deep stack of mode/interrupt-enable pairs, so the handler starts in kernel mode with interrupts off. A return-from-exception pops that stack. Hardware interrupt lines are captured into sticky pending bits. Those bits combine with a per-level mask and the current enable bit to form a single interrupt request back to the control logic.

Software reads the four registers by number through a combinational read port and updates status and pending bits through a write port. The handler entry is one constant address that the PC mux selects whenever a trap is taken. No data stream passes through the block, so every pin is a plain control or data pin. There is no valid/ready handshake and nothing applies back-pressure. The block does not decide when the pipeline flushes; it only acts on the strobes it is given.

Top module: `trap_state_regs`

## Requirements
- R1: After reset, all four registers read as zero, `irq_req` is low, and the current pair is kernel mode with interrupts disabled.
- R2: `rd_data` returns the register selected by `rd_num` in the same cycle. The numbers are 8 for the bad address, 12 for status, 13 for cause and 14 for the exception PC. Any other number reads zero, and bits a register does not define read zero.
- R3: Status keeps the mode stack in bits 5:0, with an enable bit (bit 0 of each pair, 1 = enabled) and a mode bit (bit 1, 1 = user). Bits 1:0 are the current pair, 3:2 the previous pair and 5:4 the old pair. Taking an exception shifts bits 5:0 left by two and clears bits 1:0.
- R4: `rfe` shifts status bits 5:0 right by two and leaves bits 5:4 unchanged. If `exc_take` and `rfe` arrive in the same cycle, only the exception push happens.
- R5: On `exc_take`, the exception PC becomes `cur_pc - 4`, wrapping modulo 2^32. At all other times it holds its value.
- R6: On `exc_take`, cause bits 5:2 take `exc_code`. Code 0 is an external interrupt, 4 and 5 are address faults on load/fetch and on store, 6 and 7 are bus errors on fetch and on data, 8 is a system call, 9 a breakpoint, 10 a reserved instruction and 12 an overflow. The bad-address register loads `fault_addr` only for codes 4 and 5; every other code leaves it unchanged.
- R7: Cause bits 14:10 are the pending bits of hardware levels 0 to 4. A bit is set in the cycle after its `hw_irq` line is high and stays set whatever the mask or enable state. It clears only when software writes a 1 to it at register 13, and an arriving request wins over a clear in the same cycle.
- R8: `irq_req` is high exactly when some pending bit has its mask bit set (status bits 12:8 for levels 0 to 4) and status bit 0 is 1. It is therefore low in the cycle after an exception is taken.
- R9: A write to register 12 loads the mask (status bits 15:8) and the mode stack (bits 5:0); all other status bits stay zero. A status write is ignored in a cycle with `exc_take` or `rfe`. Writes to registers 8 and 14, and to any cause bit outside 14:10, have no effect.
- R10: `handler_pc` always equals the parameter `HANDLER_ADDR`, which defaults to 0x80000080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_take | input | 1 | Take an exception this cycle |
| exc_code | input | 4 | Reason code for the exception |
| cur_pc | input | 32 | PC at the time of the trap (already advanced by 4) |
| fault_addr | input | 32 | Data address that caused an address fault |
| rfe | input | 1 | Return from exception: pop the mode stack |
| hw_irq | input | 5 | Hardware interrupt request lines, levels 0 to 4 |
| wr_en | input | 1 | Software register write strobe |
| wr_num | input | 5 | Register number for the write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number for the read |
| rd_data | output | 32 | Read data, combinational |
| irq_req | output | 1 | Enabled, unmasked interrupt is pending |
| handler_pc | output | 32 | Fixed handler entry address for the PC mux |

## Verification
The assertions check the following on every cycle:
- each exception pushes the mode stack by exactly one pair;
- a lone return pops it and keeps the old pair;
- the exception PC and the code follow the trap inputs one cycle later and hold otherwise;
- the bad address moves only on address faults;
- a captured pending bit survives until it is explicitly cleared;
- `irq_req` falls after every trap.

Other behaviour can only be shown by the bench scenarios:
- the register numbering and the zero fill of undefined bits;
- masking and enabling of pending levels;
- the write-1-to-clear path racing an arriving request;
- the priority of a trap over a simultaneous return and status write;
- the wrap of the exception PC at address zero.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [4:0] RN_BADVA = 5'd8;
  localparam logic [4:0] RN_STAT  = 5'd12;
  localparam logic [4:0] RN_CAUSE = 5'd13;
  localparam logic [4:0] RN_EPC   = 5'd14;

  typedef enum logic [3:0] {
    EC_EXT_IRQ    = 4'd0,
    EC_ADDR_LOAD  = 4'd4,
    EC_ADDR_STORE = 4'd5,
    EC_BUS_FETCH  = 4'd6,
    EC_BUS_DATA   = 4'd7,
    EC_SYSCALL    = 4'd8,
    EC_BREAK      = 4'd9,
    EC_BAD_OP     = 4'd10,
    EC_OVERFLOW   = 4'd12
  } exc_code_e;

  function automatic logic is_addr_fault(input logic [3:0] c);
    return (c == 4'(EC_ADDR_LOAD)) || (c == 4'(EC_ADDR_STORE));
  endfunction
endpackage

// File: rtl/xs_mode_stack.sv
module xs_mode_stack #(
  parameter int unsigned PAIRS  = 3,
  parameter int unsigned MASK_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 pop,
  input  logic                 wr_en,
  input  logic [MASK_W-1:0]    wr_mask,
  input  logic [2*PAIRS-1:0]   wr_modes,
  output logic [MASK_W-1:0]    mask_q,
  output logic [2*PAIRS-1:0]   modes_q
);
  localparam int unsigned MW = 2 * PAIRS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modes_q <= '0;
      mask_q  <= '0;
    end else if (push) begin
      modes_q <= {modes_q[MW-3:0], 2'b00};
    end else if (pop) begin
      modes_q <= {modes_q[MW-1:MW-2], modes_q[MW-1:2]};
    end else if (wr_en) begin
      modes_q <= wr_modes;
      mask_q  <= wr_mask;
    end
  end

  // R3: a push enters kernel mode with interrupts off and ages every pair
  a_r3_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (modes_q[1:0] == 2'b00) && (modes_q[MW-1:2] == $past(modes_q[MW-3:0])));

  // R4: a lone pop restores the lower pairs and keeps the oldest one
  a_r4_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (modes_q[MW-3:0] == $past(modes_q[MW-1:2]))
                    && (modes_q[MW-1:MW-2] == $past(modes_q[MW-1:MW-2])));

  // R9: trap entry and return never disturb the mask
  a_r9_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |=> $stable(mask_q));
endmodule

// File: rtl/xs_pending.sv
module xs_pending #(
  parameter int unsigned LVLS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLS-1:0] irq_in,
  input  logic [LVLS-1:0] clr,
  output logic [LVLS-1:0] pend_q
);
  logic [LVLS-1:0] pend_d;

  for (genvar i = 0; i < LVLS; i++) begin : g_lvl
    assign pend_d[i] = irq_in[i] | (pend_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R7: every request line seen high is captured
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

  // R7: a pending bit without a clear stays set
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr)) == $past(pend_q & ~clr)));
endmodule

// File: rtl/xs_read_mux.sv
module xs_read_mux
  import xs_pkg::*;
(
  input  logic [4:0]      rd_num,
  input  logic [XLEN-1:0] stat_word,
  input  logic [XLEN-1:0] cause_word,
  input  logic [XLEN-1:0] epc_word,
  input  logic [XLEN-1:0] badva_word,
  output logic [XLEN-1:0] rd_data
);
  always_comb begin
    unique case (rd_num)
      RN_BADVA: rd_data = badva_word;
      RN_STAT:  rd_data = stat_word;
      RN_CAUSE: rd_data = cause_word;
      RN_EPC:   rd_data = epc_word;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import xs_pkg::*;
#(
  parameter int unsigned HW_LVLS      = 5,
  parameter int unsigned SW_LVLS      = 3,
  parameter int unsigned PAIRS        = 3,
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_take,
  input  logic [3:0]  exc_code,
  input  logic [31:0] cur_pc,
  input  logic [31:0] fault_addr,
  input  logic        rfe,
  input  logic [4:0]  hw_irq,
  input  logic        wr_en,
  input  logic [4:0]  wr_num,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_num,
  output logic [31:0] rd_data,
  output logic        irq_req,
  output logic [31:0] handler_pc
);
  localparam int unsigned MASK_W   = HW_LVLS + SW_LVLS;
  localparam int unsigned MODE_W   = 2 * PAIRS;
  localparam int unsigned MASK_LSB = 8;
  localparam int unsigned PEND_LSB = 10;
  localparam int unsigned CODE_LSB = 2;

  logic [MASK_W-1:0]  mask_q;
  logic [MODE_W-1:0]  modes_q;
  logic [HW_LVLS-1:0] pend_q;
  logic [HW_LVLS-1:0] pend_clr;
  exc_code_e          code_q;
  logic [XLEN-1:0]    epc_q;
  logic [XLEN-1:0]    badva_q;
  logic [XLEN-1:0]    stat_word;
  logic [XLEN-1:0]    cause_word;
  logic               stat_wr;

  assign stat_wr  = wr_en && (wr_num == RN_STAT);
  assign pend_clr = (wr_en && (wr_num == RN_CAUSE)) ? wr_data[PEND_LSB +: HW_LVLS] : '0;

  xs_mode_stack #(.PAIRS(PAIRS), .MASK_W(MASK_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (exc_take),
    .pop      (rfe),
    .wr_en    (stat_wr),
    .wr_mask  (wr_data[MASK_LSB +: MASK_W]),
    .wr_modes (wr_data[MODE_W-1:0]),
    .mask_q   (mask_q),
    .modes_q  (modes_q)
  );

  xs_pending #(.LVLS(HW_LVLS)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (hw_irq[HW_LVLS-1:0]),
    .clr    (pend_clr),
    .pend_q (pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= EC_EXT_IRQ;
      epc_q   <= '0;
      badva_q <= '0;
    end else if (exc_take) begin
      code_q <= exc_code_e'(exc_code);
      epc_q  <= cur_pc - 32'd4;
      if (is_addr_fault(exc_code)) badva_q <= fault_addr;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[MASK_LSB +: MASK_W] = mask_q;
    stat_word[MODE_W-1:0]         = modes_q;
  end

  always_comb begin
    cause_word = '0;
    cause_word[PEND_LSB +: HW_LVLS] = pend_q;
    cause_word[CODE_LSB +: 4]       = code_q;
  end

  xs_read_mux u_rd (
    .rd_num     (rd_num),
    .stat_word  (stat_word),
    .cause_word (cause_word),
    .epc_word   (epc_q),
    .badva_word (badva_q),
    .rd_data    (rd_data)
  );

  assign irq_req    = (|(pend_q & mask_q[HW_LVLS-1:0])) & modes_q[0];
  assign handler_pc = HANDLER_ADDR;

  // R5: the trap address points back at the faulting instruction
  a_r5_epc: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc_q == $past(cur_pc) - 32'd4);

  // R5: the trap address holds between traps
  a_r5_epc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(epc_q));

  // R6: the recorded code follows the trap input
  a_r6_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> code_q == exc_code_e'($past(exc_code)));

  // R6: the bad address moves only on address faults
  a_r6_badva_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_take && is_addr_fault(exc_code)) |=> $stable(badva_q));

  // R8: taking a trap always silences the request
  a_r8_quiet_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !irq_req);
endmodule

// File: tb/trap_state_regs_test.sv
module trap_state_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HADDR = 32'h8000_0080;

  // each row: {code, pc, fault address}
  localparam int NV = 6;
  localparam logic [67:0] VTAB [NV] = '{
    {4'd12, 32'h0000_0400, 32'h0000_DEAD},
    {4'd4,  32'h0000_1004, 32'h0000_1235},
    {4'd10, 32'h0000_0008, 32'h0000_0099},
    {4'd5,  32'h0000_2000, 32'h7FFF_FFFC},
    {4'd8,  32'h0040_0010, 32'h1111_1111},
    {4'd9,  32'h0000_0000, 32'h2222_2222}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_take = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] fault_addr = '0;
  logic        rfe = 1'b0;
  logic [4:0]  hw_irq = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_num = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_num = '0;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [31:0] handler_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  trap_state_regs uut (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
    .cur_pc(cur_pc), .fault_addr(fault_addr), .rfe(rfe), .hw_irq(hw_irq),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data), .rd_num(rd_num),
    .rd_data(rd_data), .irq_req(irq_req), .handler_pc(handler_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] n, output logic [31:0] v);
    rd_num = n;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    wr_en = 1'b1; wr_num = n; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  m_modes;
    logic [7:0]  m_mask;
    logic [31:0] m_bad;
    logic [3:0]  m_code;

    cyc(); cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state and R2 numbering
    rd(5'd8, v);  chk("R1 badaddr", v, 32'h0);
    rd(5'd12, v); chk("R1 status", v, 32'h0);
    rd(5'd13, v); chk("R1 cause", v, 32'h0);
    cyc();
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    chk("R1 irq_req", {31'h0, irq_req}, 32'h0);
    chk("R10 handler", handler_pc, HADDR);

    // R9 status write with undefined bits zero
    wr(5'd12, 32'hFFFF_FF3F);
    rd(5'd12, v); chk("R9 status write", v, 32'h0000_FF3F);
    wr(5'd12, 32'h0000_003F);
    m_modes = 6'h3F; m_mask = 8'h00; m_bad = 32'h0; m_code = 4'd0;

    // table walk: trap then return (R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  c;
      logic [31:0] pc, va;
      {c, pc, va} = VTAB[i];
      exc_take = 1'b1; exc_code = c; cur_pc = pc; fault_addr = va;
      cyc();
      exc_take = 1'b0;
      m_modes = {m_modes[3:0], 2'b00};
      if (c == 4'd4 || c == 4'd5) m_bad = va;
      m_code = c;
      rd(5'd14, v); chk("R5 epc", v, pc - 32'd4);
      rd(5'd13, v); chk("R6 cause code", v, {26'h0, c, 2'b00});
      rd(5'd8, v);  chk("R6 badaddr", v, m_bad);
      cyc();
      rd(5'd12, v); chk("R3 push", v, {16'h0, m_mask, 2'b00, m_modes});
      rfe = 1'b1;
      cyc();
      rfe = 1'b0;
      m_modes = {m_modes[5:4], m_modes[5:2]};
      rd(5'd12, v); chk("R4 pop", v, {16'h0, m_mask, 2'b00, m_modes});
    end

    // R7 / R8 pending, masking and enable
    wr(5'd12, 32'h0000_0001);
    hw_irq = 5'b00100;
    cyc();
    hw_irq = 5'b0;
    rd(5'd13, v); chk("R7 capture", v, 32'h0000_1000 | {26'h0, m_code, 2'b00});
    chk("R8 masked", {31'h0, irq_req}, 32'h0);
    wr(5'd12, 32'h0000_0401);
    chk("R8 enabled", {31'h0, irq_req}, 32'h1);
    wr(5'd12, 32'h0000_0400);
    chk("R8 disabled", {31'h0, irq_req}, 32'h0);
    rd(5'd13, v); chk("R7 held while disabled", v, 32'h0000_1000 | {26'h0, m_code, 2'b00});
    wr(5'd13, 32'h0000_1000);
    rd(5'd13, v); chk("R7 clear", v, {26'h0, m_code, 2'b00});

    // R7 arrival wins over clear
    hw_irq = 5'b00100;
    wr(5'd13, 32'hFFFF_FFFF);
    hw_irq = 5'b0;
    rd(5'd13, v); chk("R7 arrival wins", v, 32'h0000_1000 | {26'h0, m_code, 2'b00});

    // R8 trap drops the request
    wr(5'd12, 32'h0000_0401);
    chk("R8 raised", {31'h0, irq_req}, 32'h1);
    exc_take = 1'b1; exc_code = 4'd0; cur_pc = 32'h0000_3000; fault_addr = 32'hAAAA_0000;
    cyc();
    exc_take = 1'b0;
    chk("R8 after trap", {31'h0, irq_req}, 32'h0);
    rd(5'd12, v); chk("R3 push interrupt", v, 32'h0000_0404);
    rd(5'd13, v); chk("R6 interrupt code", v, 32'h0000_1000);
    rfe = 1'b1;
    cyc();
    rfe = 1'b0;
    chk("R4 R8 restored", {31'h0, irq_req}, 32'h1);

    // R4 / R9 trap wins over return and status write
    exc_take = 1'b1; exc_code = 4'd7; cur_pc = 32'h0000_5000;
    rfe = 1'b1;
    wr_en = 1'b1; wr_num = 5'd12; wr_data = 32'h0000_FF3F;
    cyc();
    exc_take = 1'b0; rfe = 1'b0; wr_en = 1'b0;
    rd(5'd12, v); chk("R4 R9 trap priority", v, 32'h0000_0404);
    rd(5'd8, v);  chk("R6 bus error keeps badaddr", v, m_bad);

    // R9 writes to other registers ignored, R2 unknown numbers
    wr(5'd14, 32'h1234_5678);
    rd(5'd14, v); chk("R9 epc not writable", v, 32'h0000_4FFC);
    wr(5'd8, 32'h1234_5678);
    rd(5'd8, v);  chk("R9 badaddr not writable", v, m_bad);
    rd(5'd3, v);  chk("R2 unknown 3", v, 32'h0);
    cyc();
    rd(5'd9, v);  chk("R2 unknown 9", v, 32'h0);
    rd(5'd15, v); chk("R2 unknown 15", v, 32'h0);
    chk("R10 handler stable", handler_pc, HADDR);

    finish_run();
  end
endmodule